// File: doc/BRIEF.md
# Write-Once Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache with 16-byte lines. It sits between a processor load/store port and a 32-bit memory bus. The processor issues one load or store at a time using a request/ready handshake. The controller stalls the processor until the access finishes, whether that is a hit, a line fill, a write-back or a write-through. Each request also carries the attribute of the page it targets: shared (global) or private. A mode input selects write-through or copy-back handling of stores.

In copy-back mode every line moves through four states: invalid, clean, written-once and dirty. The first store to a clean line in a shared page is also sent to memory, so that other caches watching the bus can drop their copies. Only that store's word goes out, with its own byte enables. A store to a clean line in a private page, or any further store to a written-once line, only marks the line dirty locally. Dirty lines are written back as four beats before a new line is filled in their place. Another bus master's write arrives on the snoop input and invalidates a matching resident line.

Top module: `wo_cache`

## Requirements
- R1: After reset `ready_o` and `mem_req_o` are low and every line is invalid, so the first load to any address misses.
- R2: A load that hits returns the stored word and makes no bus access.
- R3: A miss fills the line with four read beats at word offsets 0, 1, 2, 3 in that order, each with `mem_be_o`=4'b1111. After the fill the access completes as a hit.
- R4: A miss whose victim line is dirty first writes that victim back as four write beats with `mem_be_o`=4'b1111. Clean and written-once victims are dropped with no bus access.
- R5: In copy-back mode, a store to a clean resident line with `global_i`=1 makes exactly one write beat, to the store's word address with the store's byte enables. The line becomes written-once.
- R6: In copy-back mode, a store to a clean resident line with `global_i`=0 makes no bus write, and the line becomes dirty.
- R7: In copy-back mode, a store to a written-once or dirty line makes no bus write, and the line becomes (or stays) dirty.
- R8: When `copyback_i`=0, every store makes exactly one write beat with its byte enables. A store that hits also updates the line without changing its state. A store that misses allocates nothing.
- R9: In copy-back mode, a store that misses allocates the line by a fill (with write-back of a dirty victim), then proceeds as a store to a clean line.
- R10: `snoop_valid_i` with a line address `snoop_line_i` invalidates the matching valid line, so the next load to it refetches from memory.
- R11: While `mem_req_o` is high and `mem_ack_i` is low, the bus address, direction and byte enables stay stable.
- R12: `ready_o` is high for exactly one cycle per request, and no bus request is active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| copyback_i | input | 1 | 1 selects copy-back, 0 selects write-through (sampled at request) |
| req_i | input | 1 | Processor access request, held until `ready_o` |
| we_i | input | 1 | 1 for store, 0 for load |
| addr_i | input | WADDR_W | Word address of the access |
| wdata_i | input | 32 | Store data |
| be_i | input | 4 | Store byte enables |
| global_i | input | 1 | Page attribute: 1 shared, 0 private |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Load data, valid with `ready_o` |
| mem_req_o | output | 1 | Bus beat request |
| mem_we_o | output | 1 | Bus beat is a write |
| mem_addr_o | output | WADDR_W | Bus word address |
| mem_wdata_o | output | 32 | Bus write data |
| mem_be_o | output | 4 | Bus byte enables |
| mem_ack_i | input | 1 | Bus beat accepted this cycle |
| mem_rdata_i | input | 32 | Bus read data, valid with `mem_ack_i` |
| snoop_valid_i | input | 1 | Another master wrote the given line |
| snoop_line_i | input | WADDR_W-2 | Line address of the snooped write |

## Verification
Some rules hold on every cycle and are checked there. The bus request stays stable until it is acknowledged. Reads always carry full byte enables and every request has at least one byte enabled. The ready pulse lasts one cycle and never overlaps bus activity. The write-once behaviour needs a history of accesses before it can be seen, so only the bench's scenarios show it. Those scenarios show the first shared store going through while private and repeated stores stay silent, dirty victims being written back, snoop-driven refetch, and the no-allocate store path in write-through mode. The bench shows these by counting read and write beats per access and by comparing loaded data with a reference memory.

// File: rtl/wo_cache_pkg.sv
package wo_cache_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_CLEAN = 2'd1,
    LS_ONCE  = 2'd2,
    LS_DIRTY = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    C_IDLE, C_LOOK, C_WB, C_FILL, C_WT, C_RESP
  } ctl_e;

  localparam int unsigned WORDS_PER_LINE = 4;
endpackage

// File: rtl/wo_meta_store.sv
module wo_meta_store
  import wo_cache_pkg::*;
#(
  parameter int unsigned LINES = 8,
  parameter int unsigned TAG_W = 25,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o,
  output line_st_e         rd_st_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  line_st_e         wr_st_i,
  input  logic             snp_en_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [TAG_W-1:0] snp_tag_i
);
  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= LS_INV;
        tag_q[i] <= '0;
      end
    end else begin
      if (wr_en_i) begin
        st_q[wr_idx_i]  <= wr_st_i;
        tag_q[wr_idx_i] <= wr_tag_i;
      end
      // snoop wins over a same-cycle update
      if (snp_en_i && st_q[snp_idx_i] != LS_INV && tag_q[snp_idx_i] == snp_tag_i)
        st_q[snp_idx_i] <= LS_INV;
    end
  end

  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_st_o  = st_q[rd_idx_i];
endmodule

// File: rtl/wo_data_store.sv
module wo_data_store #(
  parameter int unsigned LINES = 8,
  localparam int unsigned IDX_W = $clog2(LINES),
  localparam int unsigned A_W   = IDX_W + 2
) (
  input  logic           clk_i,
  input  logic [A_W-1:0] rd_addr_i,
  output logic [31:0]    rd_data_o,
  input  logic           wr_en_i,
  input  logic [A_W-1:0] wr_addr_i,
  input  logic [31:0]    wr_data_i,
  input  logic [3:0]     wr_be_i
);
  logic [31:0] mem_q [LINES*4];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < 4; b++)
        if (wr_be_i[b]) mem_q[wr_addr_i][8*b +: 8] <= wr_data_i[8*b +: 8];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/wo_cache.sv
module wo_cache
  import wo_cache_pkg::*;
#(
  parameter int unsigned WADDR_W = 30,
  parameter int unsigned LINES   = 8,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = WADDR_W - 2 - IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               copyback_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [WADDR_W-1:0] addr_i,
  input  logic [31:0]        wdata_i,
  input  logic [3:0]         be_i,
  input  logic               global_i,
  output logic               ready_o,
  output logic [31:0]        rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic [31:0]        mem_wdata_o,
  output logic [3:0]         mem_be_o,
  input  logic               mem_ack_i,
  input  logic [31:0]        mem_rdata_i,
  input  logic               snoop_valid_i,
  input  logic [WADDR_W-3:0] snoop_line_i
);
  ctl_e               ctl_q, ctl_d;
  logic [1:0]         beat_q, beat_d;
  logic               op_we_q, op_glb_q, op_cb_q;
  logic [WADDR_W-1:0] op_addr_q;
  logic [31:0]        op_wdata_q;
  logic [3:0]         op_be_q;
  logic [31:0]        rdata_q, rdata_d;

  logic [IDX_W-1:0]   idx;
  logic [TAG_W-1:0]   tag;
  logic [1:0]         word;
  logic [TAG_W-1:0]   rd_tag;
  line_st_e           rd_st;
  logic               hit, victim_dirty;

  logic               mw_en;
  logic [TAG_W-1:0]   mw_tag;
  line_st_e           mw_st;
  logic               dw_en;
  logic [1:0]         dw_word, dr_word;
  logic [31:0]        dw_data, dr_data;
  logic [3:0]         dw_be;

  assign idx  = op_addr_q[2 +: IDX_W];
  assign word = op_addr_q[1:0];
  assign tag  = op_addr_q[WADDR_W-1 -: TAG_W];

  wo_meta_store #(.LINES(LINES), .TAG_W(TAG_W)) u_meta (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (idx),
    .rd_tag_o  (rd_tag),
    .rd_st_o   (rd_st),
    .wr_en_i   (mw_en),
    .wr_idx_i  (idx),
    .wr_tag_i  (mw_tag),
    .wr_st_i   (mw_st),
    .snp_en_i  (snoop_valid_i),
    .snp_idx_i (snoop_line_i[IDX_W-1:0]),
    .snp_tag_i (snoop_line_i[WADDR_W-3 -: TAG_W])
  );

  wo_data_store #(.LINES(LINES)) u_data (
    .clk_i     (clk_i),
    .rd_addr_i ({idx, dr_word}),
    .rd_data_o (dr_data),
    .wr_en_i   (dw_en),
    .wr_addr_i ({idx, dw_word}),
    .wr_data_i (dw_data),
    .wr_be_i   (dw_be)
  );

  assign hit          = (rd_st != LS_INV) && (rd_tag == tag);
  assign victim_dirty = (rd_st == LS_DIRTY);
  assign dr_word      = (ctl_q == C_WB) ? beat_q : word;

  function automatic line_st_e store_next(line_st_e s, logic glb);
    return (s == LS_CLEAN && glb) ? LS_ONCE : LS_DIRTY;
  endfunction

  always_comb begin
    ctl_d       = ctl_q;
    beat_d      = beat_q;
    rdata_d     = rdata_q;
    mw_en       = 1'b0;
    mw_tag      = tag;
    mw_st       = rd_st;
    dw_en       = 1'b0;
    dw_word     = word;
    dw_data     = op_wdata_q;
    dw_be       = op_be_q;
    ready_o     = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {tag, idx, beat_q};
    mem_wdata_o = dr_data;
    mem_be_o    = 4'hf;
    unique case (ctl_q)
      C_IDLE: if (req_i) ctl_d = C_LOOK;
      C_LOOK: begin
        if (!op_we_q) begin
          if (hit) begin
            rdata_d = dr_data;
            ctl_d   = C_RESP;
          end else begin
            ctl_d = victim_dirty ? C_WB : C_FILL;
          end
        end else if (!op_cb_q) begin
          dw_en = hit;
          ctl_d = C_WT;
        end else if (hit) begin
          dw_en = 1'b1;
          mw_en = 1'b1;
          mw_st = store_next(rd_st, op_glb_q);
          ctl_d = (rd_st == LS_CLEAN && op_glb_q) ? C_WT : C_RESP;
        end else begin
          ctl_d = victim_dirty ? C_WB : C_FILL;
        end
      end
      C_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = {rd_tag, idx, beat_q};
        if (mem_ack_i) begin
          beat_d = beat_q + 2'd1;
          if (beat_q == 2'd3) ctl_d = C_FILL;
        end
      end
      C_FILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          dw_en   = 1'b1;
          dw_word = beat_q;
          dw_data = mem_rdata_i;
          dw_be   = 4'hf;
          beat_d  = beat_q + 2'd1;
          if (beat_q == 2'd3) begin
            mw_en = 1'b1;
            mw_st = LS_CLEAN;
            ctl_d = C_LOOK;
          end
        end
      end
      C_WT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = op_addr_q;
        mem_wdata_o = op_wdata_q;
        mem_be_o    = op_be_q;
        if (mem_ack_i) ctl_d = C_RESP;
      end
      C_RESP: begin
        ready_o = 1'b1;
        ctl_d   = C_IDLE;
      end
      default: ctl_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q      <= C_IDLE;
      beat_q     <= '0;
      rdata_q    <= '0;
      op_we_q    <= 1'b0;
      op_glb_q   <= 1'b0;
      op_cb_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      op_be_q    <= '0;
    end else begin
      ctl_q   <= ctl_d;
      beat_q  <= beat_d;
      rdata_q <= rdata_d;
      if (ctl_q == C_IDLE && req_i) begin
        op_we_q    <= we_i;
        op_glb_q   <= global_i;
        op_cb_q    <= copyback_i;
        op_addr_q  <= addr_i;
        op_wdata_q <= wdata_i;
        op_be_q    <= be_i;
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/wo_cache_chk.sv
module wo_cache_chk #(
  parameter int unsigned WADDR_W = 30
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ready_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [WADDR_W-1:0] mem_addr_o,
  input logic [3:0]         mem_be_o,
  input logic               mem_ack_i
);
  p_ready_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_ready_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_req_o);

  p_bus_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_be_o)));

  p_read_full_be_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> (mem_be_o == 4'hf));

  p_be_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_be_o != 4'h0));
endmodule

bind wo_cache wo_cache_chk #(.WADDR_W(WADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o),
  .mem_ack_i  (mem_ack_i)
);

// File: tb/wo_cache_test.sv
module wo_cache_test;
  localparam int unsigned WA = 30;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          copyback_i = 1'b1;
  logic          req_i = 1'b0, we_i = 1'b0, global_i = 1'b0;
  logic [WA-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [3:0]    be_i = '0;
  logic          ready_o;
  logic [31:0]   rdata_o;
  logic          mem_req_o, mem_we_o;
  logic [WA-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic [3:0]    mem_be_o;
  logic          mem_ack_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          snoop_valid_i = 1'b0;
  logic [WA-3:0] snoop_line_i = '0;

  wo_cache #(.WADDR_W(WA), .LINES(8)) uut (.*);

  always #4 clk_i = ~clk_i; // 8 ns period

  int nchk = 0, nfail = 0;
  logic [31:0] mem [128];
  logic [31:0] ref_m [128];
  int          mst [8];  // 0 inv, 1 clean, 2 once, 3 dirty
  logic [1:0]  mtag [8];
  int          rd_n, wr_n;
  logic [3:0]  last_be;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  // bus slave with random wait states
  always @(negedge clk_i) begin
    if (mem_req_o && rst_ni && ($urandom % 4 != 0)) begin
      mem_ack_i = 1'b1;
      if (mem_we_o) begin
        mem[mem_addr_o[6:0]] = merge(mem[mem_addr_o[6:0]], mem_wdata_o, mem_be_o);
        wr_n++;
        last_be = mem_be_o;
      end else begin
        chk(mem_addr_o[1:0] == 2'(rd_n), "R3", "fill beat order",
            32'(mem_addr_o[1:0]), 32'(rd_n % 4));
        mem_rdata_i = mem[mem_addr_o[6:0]];
        rd_n++;
      end
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  // page attribute: tags 0,1 shared, tags 2,3 private
  function automatic bit page_glb(logic [6:0] wa);
    return !wa[6];
  endfunction

  task automatic run_op(bit we, logic [6:0] wa, logic [31:0] wd, logic [3:0] be, string req);
    int idx = int'(wa[4:2]);
    logic [1:0] tg = wa[6:5];
    bit g = page_glb(wa);
    bit cb = copyback_i;
    bit hit = (mst[idx] != 0) && (mtag[idx] == tg);
    int e_rd = 0, e_wr = 0, waited = 0;
    logic [31:0] e_data = ref_m[wa];
    if (!we || (cb && !hit)) begin
      if (!hit) begin
        e_rd = 4;
        e_wr = (mst[idx] == 3) ? 4 : 0;
        mtag[idx] = tg;
        mst[idx] = 1;
      end
    end
    if (we) begin
      ref_m[wa] = merge(ref_m[wa], wd, be);
      if (!cb) e_wr += 1;
      else begin
        if (mst[idx] == 1 && g) begin e_wr += 1; mst[idx] = 2; end
        else mst[idx] = 3;
      end
    end
    rd_n = 0; wr_n = 0; last_be = 4'h0;
    req_i = 1'b1; we_i = we; addr_i = WA'(wa); wdata_i = wd; be_i = be; global_i = g;
    do begin
      @(negedge clk_i);
      waited++;
    end while (!ready_o && waited < 400);
    req_i = 1'b0;
    chk(ready_o, req, "request completes", 32'(ready_o), 32'd1);
    chk(rd_n == e_rd, req, "read beats", 32'(rd_n), 32'(e_rd));
    chk(wr_n == e_wr, req, "write beats", 32'(wr_n), 32'(e_wr));
    if (!we) chk(rdata_o == e_data, req, "load data", rdata_o, e_data);
    if (we && !(cb && e_wr == 4))
      if (e_wr != 0) chk(last_be == be, req, "write-through byte enables", 32'(last_be), 32'(be));
    @(negedge clk_i);
    chk(!ready_o, "R12", "ready single cycle", 32'(ready_o), 32'd0);
  endtask

  task automatic snoop(logic [6:0] wa, logic [31:0] nv);
    int idx = int'(wa[4:2]);
    if (mst[idx] == 3 && mtag[idx] == wa[6:5]) return; // never snoop a dirty owner
    mem[wa] = nv; ref_m[wa] = nv;
    if (mst[idx] != 0 && mtag[idx] == wa[6:5]) mst[idx] = 0;
    snoop_valid_i = 1'b1; snoop_line_i = (WA-2)'(wa[6:2]);
    @(negedge clk_i);
    snoop_valid_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    #1_200_000;
    nfail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 32'(i) * 32'h9e3779b9 ^ 32'h5a5a0000;
      ref_m[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin mst[i] = 0; mtag[i] = 0; end
    repeat (3) @(negedge clk_i);
    chk(!ready_o && !mem_req_o, "R1", "idle after reset", {ready_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!ready_o && !mem_req_o, "R1", "quiet out of reset", {ready_o, mem_req_o}, 0);

    // directed corner cases, copy-back
    run_op(0, 7'h04, 0, 0, "R1");                       // cold miss
    run_op(0, 7'h05, 0, 0, "R2");                       // hit
    run_op(1, 7'h05, 32'hdeadbeef, 4'b0110, "R5");     // clean + shared -> once
    run_op(1, 7'h06, 32'h11223344, 4'b0001, "R7");     // once -> dirty
    run_op(0, 7'h24, 0, 0, "R4");                       // dirty victim evicted
    run_op(0, 7'h06, 0, 0, "R4");                       // clean victim dropped
    run_op(0, 7'h48, 0, 0, "R3");
    run_op(1, 7'h49, 32'hcafef00d, 4'b1111, "R6");     // private: silent
    run_op(1, 7'h6a, 32'h0badc0de, 4'b1000, "R9");     // miss + dirty victim, private
    run_op(1, 7'h30, 32'h55aa55aa, 4'b0011, "R9");     // miss, shared
    run_op(0, 7'h10, 0, 0, "R10");
    snoop(7'h12, 32'h76543210);
    run_op(0, 7'h12, 0, 0, "R10");                      // refetch
    copyback_i = 1'b0;
    run_op(1, 7'h5c, 32'h01020304, 4'b0101, "R8");     // miss, no allocate
    run_op(0, 7'h5c, 0, 0, "R8");
    run_op(1, 7'h5d, 32'ha0b0c0d0, 4'b1100, "R8");     // hit, stays clean
    run_op(0, 7'h5d, 0, 0, "R8");

    // constrained random
    for (int n = 0; n < 500; n++) begin
      logic [6:0]  wa = 7'($urandom);
      bit          st = ($urandom % 2) == 1;
      logic [3:0]  be = 4'($urandom);
      copyback_i = !(n >= 200 && n < 300);
      if (be == 0) be = 4'b0001;
      if ($urandom % 8 == 0) snoop(7'($urandom), $urandom);
      run_op(st, wa, $urandom, be, st ? (copyback_i ? "R7" : "R8") : "R2");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule